// File: doc/BRIEF.md
# Keyed Configuration Port

This block guards a small configuration register space behind a two-byte address window on a byte-wide bus. The lower address of the window holds both the index register and the key-entry register. The upper address is the data register. After reset the window is locked. Data-port reads return 0xFF and data-port writes do nothing until software writes the enter key to the index address twice in a row. Writing the leave key to the same address closes the window again.

While the window is open, a byte written to the index address selects a configuration register, and the data address reads or writes it. Two registers are held inside the block. Index 0x07 is the bank selector, which is the logical device number that picks the bank visible to the function logic. Index 0x20 is a read-only device identity byte set by a parameter; a value of 0xFF there means that no device is present. Accesses to every other index are passed on to the function logic. The block drives write and read strobes, the current index, the bank selector and the write byte, and it takes the read byte back combinationally. Read data is registered and appears on the bus one cycle after the read.

Top module: `cfg_key_port`

## Requirements
- R1: After reset the window is locked (`cfg_open` = 0), `io_rdata` is 0xFF, and both bank strobes are low.
- R2: Two consecutive writes of the enter key (0x87 by default) to `BASE_ADDR` open the window; `cfg_open` is high in the cycle after the second write.
- R3: While the window is locked, any write to `BASE_ADDR` other than the enter key, and any write to `BASE_ADDR`+1, clears a half-entered key. Two fresh enter-key writes are then needed to open the window.
- R4: Writing the leave key (0xAA by default) to `BASE_ADDR` while the window is open locks it again. The leave key is not loaded as an index, so the previous index is still there after the next unlock.
- R5: While the window is locked, reads of either port return 0xFF and writes to `BASE_ADDR`+1 are ignored: no bank strobe is raised and the bank selector keeps its value.
- R6: Writing the enter key while the window is open keeps it open, and the key byte is not loaded as an index.
- R7: With `ALT_KEYS` = 1 the enter key is 0x88 and the leave key is 0xBB; the default bytes 0x87 and 0xAA then have no key effect.
- R8: Index 0x07 is the bank selector. A data write stores the byte, a data read returns it, and `bank_ldn` shows it.
- R9: Index 0x20 reads back `DEV_ID` (default 0xA3). Data writes to it are ignored and raise no strobe.
- R10: For any other index, a data write raises `bank_wr` for exactly that cycle, with `bank_index`, `bank_ldn` and `bank_wdata` valid. A data read raises `bank_rd` and returns `bank_rdata`.
- R11: Bus accesses to addresses other than `BASE_ADDR` and `BASE_ADDR`+1 have no effect. `BASE_ADDR` is a parameter, typically 0x2E or 0x4E.
- R12: `io_rdata` takes its new value at the clock edge that ends a read cycle and holds it until the next decoded read. When the window is open, a read of `BASE_ADDR` returns the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W | Bus address |
| io_wr | input | 1 | Bus write strobe, one cycle per access |
| io_rd | input | 1 | Bus read strobe, one cycle per access |
| io_wdata | input | 8 | Bus write byte |
| io_rdata | output | 8 | Registered bus read byte |
| cfg_open | output | 1 | Window is unlocked |
| bank_ldn | output | 8 | Selected logical device number |
| bank_index | output | 8 | Current configuration index |
| bank_wdata | output | 8 | Byte to write into the bank |
| bank_wr | output | 1 | Bank register write strobe |
| bank_rd | output | 1 | Bank register read strobe |
| bank_rdata | input | 8 | Bank register read byte, combinational on index and selector |

## Verification
The assertions check on every cycle the rules that can be seen from the ports alone. A locked window never raises a bank strobe and a locked read always returns 0xFF. Every rise of `cfg_open` follows an enter-key write to the index address. A leave key always closes the window, and a repeated enter key keeps it open without moving the index. Read data stays stable when no read occurs. Some behaviour can only be shown by the bench's scenarios: a half-entered key being cleared, the index surviving a relock, the alternate key pair, address decoding, and the round trips through the bank selector, the identity byte and the downstream bank.

// File: rtl/cfg_key_port_pkg.sv
// Package: shared types and key constants for the keyed configuration port.
// Assumes byte-wide configuration data throughout.
package cfg_key_port_pkg;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_ARMED  = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_t;

    localparam logic [7:0] IDX_LDN   = 8'h07;
    localparam logic [7:0] IDX_ID    = 8'h20;
    localparam logic [7:0] RD_IDLE   = 8'hFF;

    // Returns the unlock byte for the chosen key pair.
    function automatic logic [7:0] enter_key(input bit alt);
        return alt ? 8'h88 : 8'h87;
    endfunction

    // Returns the relock byte for the chosen key pair.
    function automatic logic [7:0] leave_key(input bit alt);
        return alt ? 8'hBB : 8'hAA;
    endfunction

endpackage

// File: rtl/cfg_key_fsm.sv
// Key sequencer: tracks the lock state from writes to the index and data
// addresses. Assumes idx_wr and dat_wr are never high together.
module cfg_key_fsm
    import cfg_key_port_pkg::*;
#(
    parameter bit ALT_KEYS = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    output logic       open,
    output logic       idx_load
);
    localparam logic [7:0] K_ENTER = enter_key(ALT_KEYS);
    localparam logic [7:0] K_LEAVE = leave_key(ALT_KEYS);

    key_state_t state_q, state_d;
    logic       is_enter, is_leave;

    assign is_enter = (wdata == K_ENTER);
    assign is_leave = (wdata == K_LEAVE);

    // Next-state selection for the unlock sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_LOCKED: if (idx_wr && is_enter) state_d = KS_ARMED;
            KS_ARMED: begin
                if (idx_wr)      state_d = is_enter ? KS_OPEN : KS_LOCKED;
                else if (dat_wr) state_d = KS_LOCKED;
            end
            KS_OPEN:   if (idx_wr && is_leave) state_d = KS_LOCKED;
            default:   state_d = KS_LOCKED;
        endcase
    end

    // State register with synchronous reset to locked.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_LOCKED;
        else        state_q <= state_d;
    end

    assign open     = (state_q == KS_OPEN);
    assign idx_load = idx_wr && open && !is_enter && !is_leave;

endmodule

// File: rtl/cfg_reg_decode.sv
// Register decode: holds the index and bank selector, and raises bank
// strobes for indices not held locally. Assumes one access per cycle.
module cfg_reg_decode
    import cfg_key_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       open,
    input  logic       idx_load,
    input  logic       dat_wr,
    input  logic       dat_rd,
    input  logic [7:0] wdata,
    output logic [7:0] index,
    output logic [7:0] ldn,
    output logic       bank_wr,
    output logic       bank_rd
);
    logic local_reg;

    assign local_reg = (index == IDX_LDN) || (index == IDX_ID);

    // Index and bank-selector storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index <= 8'h00;
            ldn   <= 8'h00;
        end else begin
            if (idx_load) index <= wdata;
            if (dat_wr && open && index == IDX_LDN) ldn <= wdata;
        end
    end

    assign bank_wr = dat_wr && open && !local_reg;
    assign bank_rd = dat_rd && open && !local_reg;

endmodule

// File: rtl/cfg_read_reg.sv
// Read data register: captures the byte for a decoded read and holds it.
// Assumes bank_rdata is valid in the same cycle as the read.
module cfg_read_reg
    import cfg_key_port_pkg::*;
#(
    parameter logic [7:0] DEV_ID = 8'hA3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       open,
    input  logic       idx_rd,
    input  logic       dat_rd,
    input  logic [7:0] index,
    input  logic [7:0] ldn,
    input  logic [7:0] bank_rdata,
    output logic [7:0] rdata
);
    logic [7:0] dat_sel;

    // Data-port source selection by index.
    always_comb begin
        if (index == IDX_LDN)     dat_sel = ldn;
        else if (index == IDX_ID) dat_sel = DEV_ID;
        else                      dat_sel = bank_rdata;
    end

    // Capture on a decoded read, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)            rdata <= RD_IDLE;
        else if (idx_rd || dat_rd) begin
            if (!open)         rdata <= RD_IDLE;
            else if (idx_rd)   rdata <= index;
            else               rdata <= dat_sel;
        end
    end

endmodule

// File: rtl/cfg_key_port.sv
// Top: decodes the two-address window and ties the key sequencer, register
// decode and read register together. Assumes single-cycle bus strobes.
module cfg_key_port #(
    parameter int         ADDR_W    = 8,
    parameter int         BASE_ADDR = 'h2E,
    parameter bit         ALT_KEYS  = 1'b0,
    parameter logic [7:0] DEV_ID    = 8'hA3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              cfg_open,
    output logic [7:0]        bank_ldn,
    output logic [7:0]        bank_index,
    output logic [7:0]        bank_wdata,
    output logic              bank_wr,
    output logic              bank_rd,
    input  logic [7:0]        bank_rdata
);
    localparam logic [ADDR_W-1:0] A_IDX = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(BASE_ADDR + 1);

    logic hit_idx, hit_dat;
    logic idx_wr, idx_rd, dat_wr, dat_rd;
    logic idx_load;

    assign hit_idx = (io_addr == A_IDX);
    assign hit_dat = (io_addr == A_DAT);
    assign idx_wr  = io_wr && hit_idx;
    assign idx_rd  = io_rd && hit_idx;
    assign dat_wr  = io_wr && hit_dat;
    assign dat_rd  = io_rd && hit_dat;

    cfg_key_fsm #(.ALT_KEYS(ALT_KEYS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .dat_wr   (dat_wr),
        .wdata    (io_wdata),
        .open     (cfg_open),
        .idx_load (idx_load)
    );

    cfg_reg_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .open     (cfg_open),
        .idx_load (idx_load),
        .dat_wr   (dat_wr),
        .dat_rd   (dat_rd),
        .wdata    (io_wdata),
        .index    (bank_index),
        .ldn      (bank_ldn),
        .bank_wr  (bank_wr),
        .bank_rd  (bank_rd)
    );

    cfg_read_reg #(.DEV_ID(DEV_ID)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .open       (cfg_open),
        .idx_rd     (idx_rd),
        .dat_rd     (dat_rd),
        .index      (bank_index),
        .ldn        (bank_ldn),
        .bank_rdata (bank_rdata),
        .rdata      (io_rdata)
    );

    assign bank_wdata = io_wdata;

endmodule

// File: rtl/cfg_key_port_chk.sv
// Checker: port-level temporal rules of the keyed configuration port.
module cfg_key_port_chk #(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h2E,
    parameter bit ALT_KEYS  = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              cfg_open,
    input logic [7:0]        bank_index,
    input logic              bank_wr,
    input logic              bank_rd
);
    localparam logic [ADDR_W-1:0] A_IDX = ADDR_W'(BASE_ADDR);
    localparam logic [7:0] K_ENTER = cfg_key_port_pkg::enter_key(ALT_KEYS);
    localparam logic [7:0] K_LEAVE = cfg_key_port_pkg::leave_key(ALT_KEYS);

    logic key_in, leave_in, idx_w;
    assign idx_w    = io_wr && io_addr == A_IDX;
    assign key_in   = idx_w && io_wdata == K_ENTER;
    assign leave_in = idx_w && io_wdata == K_LEAVE;

    // R5: locked window raises no bank strobe
    assert_locked_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |-> !bank_wr && !bank_rd);

    // R5: locked read returns idle byte
    assert_locked_read_ff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && !cfg_open |=> io_rdata == 8'hFF);

    // R2: window opens only right after an enter-key write
    assert_open_after_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(key_in));

    // R3: non-key index write while locked keeps it locked
    assert_bad_key_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open && idx_w && !key_in |=> !cfg_open);

    // R4: leave key closes the window
    assert_leave_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_open && leave_in |=> !cfg_open);

    // R6: repeated enter key keeps window open and index unchanged
    assert_reenter_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_open && key_in |=> cfg_open && $stable(bank_index));

    // R12: read data holds without a read
    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));

endmodule

bind cfg_key_port cfg_key_port_chk #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .ALT_KEYS(ALT_KEYS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cfg_open(cfg_open), .bank_index(bank_index),
    .bank_wr(bank_wr), .bank_rd(bank_rd)
);

// File: tb/cfg_key_port_test.sv
// Bench: vector table walk, then directed reset and corner-case tests.
module cfg_key_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h00;

    logic [7:0] rdata_a, ldn_a, idx_a, wdat_a, brd_a;
    logic       open_a, bwr_a, brd_s_a;
    logic [7:0] rdata_b, ldn_b, idx_b, wdat_b, brd_b;
    logic       open_b, bwr_b, brd_s_b;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    // Downstream bank model: byte derived from index and selector.
    assign brd_a = idx_a ^ {ldn_a[3:0], 4'h0} ^ 8'h3C;
    assign brd_b = idx_b ^ {ldn_b[3:0], 4'h0} ^ 8'h3C;

    cfg_key_port uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(rdata_a),
        .cfg_open(open_a), .bank_ldn(ldn_a), .bank_index(idx_a),
        .bank_wdata(wdat_a), .bank_wr(bwr_a), .bank_rd(brd_s_a),
        .bank_rdata(brd_a)
    );

    cfg_key_port #(.BASE_ADDR('h4E), .ALT_KEYS(1'b1)) uut_alt (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(rdata_b),
        .cfg_open(open_b), .bank_ldn(ldn_b), .bank_index(idx_b),
        .bank_wdata(wdat_b), .bank_wr(bwr_b), .bank_rd(brd_s_b),
        .bank_rdata(brd_b)
    );

    // Vector fields: {read, addr[8], wdata[8], expected[8], tag[4]}
    localparam int NV = 14;
    localparam logic [28:0] VEC [NV] = '{
        {1'b1, 8'h2F, 8'h00, 8'hFF, 4'd5},  // R5 locked data read
        {1'b0, 8'h2E, 8'h87, 8'h00, 4'd2},
        {1'b0, 8'h2E, 8'h87, 8'h00, 4'd2},  // R2 open
        {1'b0, 8'h2E, 8'h20, 8'h00, 4'd9},
        {1'b1, 8'h2F, 8'h00, 8'hA3, 4'd9},  // R9 identity byte
        {1'b0, 8'h2E, 8'h07, 8'h00, 4'd8},
        {1'b0, 8'h2F, 8'h08, 8'h00, 4'd8},
        {1'b1, 8'h2F, 8'h00, 8'h08, 4'd8},  // R8 selector readback
        {1'b0, 8'h2E, 8'h30, 8'h00, 4'd10},
        {1'b1, 8'h2F, 8'h00, 8'h8C, 4'd10}, // R10 bank read
        {1'b1, 8'h2E, 8'h00, 8'h30, 4'd12}, // R12 index readback
        {1'b0, 8'h2E, 8'hAA, 8'h00, 4'd4},  // R4 relock
        {1'b1, 8'h2F, 8'h00, 8'hFF, 4'd5},
        {1'b1, 8'h2E, 8'h00, 8'hFF, 4'd5}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        v = rdata_a;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 open", {7'd0, open_a}, 8'h00);
        check("R1 rdata", rdata_a, 8'hFF);
        check("R1 strobes", {6'd0, bwr_a, brd_s_a}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [28:0] v;
            v = VEC[i];
            if (v[28]) begin
                do_rd(v[27:20], got);
                check($sformatf("R%0d vec%0d", v[3:0], i), got, v[11:4]);
            end else begin
                do_wr(v[27:20], v[19:12]);
            end
        end

        // R5 locked data write ignored
        @(negedge clk);
        io_addr = 8'h2F; io_wdata = 8'h44; io_wr = 1'b1;
        #1 check("R5 no strobe", {7'd0, bwr_a}, 8'h00);
        @(negedge clk); io_wr = 1'b0;
        check("R5 selector kept", ldn_a, 8'h08);

        // R3 broken key sequences
        do_wr(8'h2E, 8'h87); do_wr(8'h2E, 8'h55); do_wr(8'h2E, 8'h87);
        check("R3 bad index byte", {7'd0, open_a}, 8'h00);
        do_wr(8'h2E, 8'h87);
        check("R3 fresh pair opens", {7'd0, open_a}, 8'h01);
        do_wr(8'h2E, 8'hAA);
        do_wr(8'h2E, 8'h87); do_wr(8'h2F, 8'h87); do_wr(8'h2E, 8'h87);
        check("R3 data write between", {7'd0, open_a}, 8'h00);
        do_wr(8'h2E, 8'h87);

        // R4 index survives relock
        do_rd(8'h2E, got);
        check("R4 index kept", got, 8'h30);

        // R6 enter key while open
        do_wr(8'h2E, 8'h87);
        check("R6 stays open", {7'd0, open_a}, 8'h01);
        do_rd(8'h2E, got);
        check("R6 index not loaded", got, 8'h30);

        // R10 bank write strobe fields
        @(negedge clk);
        io_addr = 8'h2F; io_wdata = 8'h5A; io_wr = 1'b1;
        #1 check("R10 wr strobe", {7'd0, bwr_a}, 8'h01);
        check("R10 index", idx_a, 8'h30);
        check("R10 selector", ldn_a, 8'h08);
        check("R10 wdata", wdat_a, 8'h5A);
        @(negedge clk); io_wr = 1'b0;
        #1 check("R10 one cycle", {7'd0, bwr_a}, 8'h00);

        // R9 identity write ignored
        do_wr(8'h2E, 8'h20);
        @(negedge clk);
        io_addr = 8'h2F; io_wdata = 8'h11; io_wr = 1'b1;
        #1 check("R9 no strobe", {7'd0, bwr_a}, 8'h00);
        @(negedge clk); io_wr = 1'b0;
        do_rd(8'h2F, got);
        check("R9 id unchanged", got, 8'hA3);

        // R12 read data holds through idle cycles
        repeat (3) @(negedge clk);
        check("R12 hold", rdata_a, 8'hA3);

        // R11 other address: leave key at wrong address has no effect
        do_wr(8'h2C, 8'hAA);
        check("R11 wrong addr", {7'd0, open_a}, 8'h01);
        do_wr(8'h2E, 8'hAA);
        do_wr(8'h4E, 8'h87); do_wr(8'h4E, 8'h87);
        check("R11 default unit ignores 4E", {7'd0, open_a}, 8'h00);

        // R7 alternate key pair on second unit
        check("R7 default key no effect", {7'd0, open_b}, 8'h00);
        do_wr(8'h4E, 8'h88); do_wr(8'h4E, 8'h88);
        check("R7 alt enter", {7'd0, open_b}, 8'h01);
        do_wr(8'h4E, 8'hAA);
        check("R7 default leave no effect", {7'd0, open_b}, 8'h01);
        do_wr(8'h4E, 8'hBB);
        check("R7 alt leave", {7'd0, open_b}, 8'h00);

        // R1 reset mid-run returns to locked
        do_wr(8'h2E, 8'h87); do_wr(8'h2E, 8'h87);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 reset relocks", {7'd0, open_a}, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule